// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is the master side of a byte-wide slave-parallel FPGA configuration port. On a start pulse it runs one of two sequences. A load sequence pulses the device's program pin, waits for the device to leave its clearing state, and streams configuration bytes from a valid/ready input onto the data bus. It strobes one clock pulse per byte, and it can optionally add clock pulses while the device reports busy. It then releases the strobes and keeps clocking until the device reports done. A readback sequence selects the device, clocks it, and captures a requested number of bytes from the bus into an output stream.

Every pin step lasts one half period of the configuration clock. That half period is set as a count of system-clock cycles. Each of the three waits (clearing, busy, done) is bounded by a cycle-count limit. When a limit runs out, the block raises `abort_o` and `fail_o` for one cycle and returns to idle. A normal finish raises `pass_o` for one cycle. Pad tristating is left to the pad ring; the block only drives the data-bus enable `dbus_oe_o`.

Top module: `cfgld_top`

## Requirements
- R1: After reset, `prog_o`, `cs_o`, `wr_o`, `cclk_o`, `dbus_oe_o`, `cfg_ready_o`, `rb_valid_o`, `pass_o`, `fail_o` and `abort_o` are all 0. Asserting `rst_n` low in the middle of a sequence returns all of them to 0 at once.
- R2: A load (`start_i` with `mode_rb_i`=0) begins with `prog_o` high for exactly HALF_CYC cycles while `cs_o`, `wr_o` and `cclk_o` stay low. `prog_o` then goes low.
- R3: After `prog_o` is released, the block advances only once `init_i` and `busy_i` are not both 1. If they remain both 1 for TMO_CYC cycles, the load ends with `abort_o` and `fail_o`.
- R4: Before the first byte, `wr_o` rises first, then `cs_o`, then `cclk_o`. Each step is one half period after the last, so `cs_o` rises while `wr_o` is 1 and `cclk_o` is 0.
- R5: A byte is taken on a cycle with `cfg_valid_i` and `cfg_ready_o` both 1. The next cycle it is on `dbus_o` with `cclk_o` low; `cclk_o` then returns high. Bytes reach the bus in stream order, one falling `cclk_o` edge per byte, and the byte flagged by `cfg_last_i` is the final one.
- R6: With `busy_chk_i`=1, if `busy_i` is 1 at the end of a byte's high phase, the block issues extra `cclk_o` pulses until `busy_i` is 0. If `busy_i` stays 1 for TMO_CYC cycles, the load ends with `abort_o` and `fail_o`.
- R7: With `busy_chk_i`=0, `busy_i` has no effect during the byte phase: exactly one `cclk_o` fall per byte.
- R8: After the last byte, `cs_o` falls while `wr_o` is still 1, and `wr_o` falls one half period later.
- R9: After `wr_o` falls, `cclk_o` keeps pulsing until `done_i` is 1, and then `pass_o` pulses. If `done_i` stays 0 for TMO_CYC cycles, the load ends with `abort_o` and `fail_o`. `pass_o` and `fail_o` are never 1 together.
- R10: A readback (`start_i` with `mode_rb_i`=1) raises `cs_o` with `cclk_o` low and then drives `cclk_o` high. For each of the `rb_len_i` bytes it drives `cclk_o` low, then high, then samples `dbus_i` at the end of the high phase. Each sample appears on `rb_data_o` with a one-cycle `rb_valid_o`. A length of 0 captures nothing. `wr_o` stays 0 throughout.
- R11: After the last readback byte, `cs_o` falls with `cclk_o` high. Exactly one more full `cclk_o` pulse (one rising edge) follows before `pass_o`.
- R12: `dbus_oe_o` is 1 only while a load is in progress and is 0 for the whole of a readback. `cfg_ready_o` is never 1 during a readback.
- R13: `start_i` is ignored while a sequence is running: no readback byte, no restart, and a single result pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to start a sequence (accepted in idle only) |
| mode_rb_i | input | 1 | Sequence select at start: 0 load, 1 readback |
| rb_len_i | input | LEN_W | Number of bytes to read back, sampled at start |
| busy_chk_i | input | 1 | 1 enables extra clocking while busy after each byte |
| cfg_data_i | input | DW | Configuration byte stream data |
| cfg_valid_i | input | 1 | Stream byte valid |
| cfg_last_i | input | 1 | Marks the final byte of the stream |
| cfg_ready_o | output | 1 | Block can take a byte this cycle |
| rb_data_o | output | DW | Captured readback byte |
| rb_valid_o | output | 1 | One-cycle strobe for `rb_data_o` |
| prog_o | output | 1 | Program request to the device, active high |
| cs_o | output | 1 | Chip select to the device, active high |
| wr_o | output | 1 | Write strobe to the device, active high |
| cclk_o | output | 1 | Configuration clock to the device |
| dbus_o | output | DW | Data bus, output side |
| dbus_oe_o | output | 1 | Data bus output enable for the pad |
| dbus_i | input | DW | Data bus, input side |
| init_i | input | 1 | Device clearing indicator |
| busy_i | input | 1 | Device busy indicator |
| done_i | input | 1 | Device configuration complete |
| abort_o | output | 1 | One-cycle pulse on any timeout |
| pass_o | output | 1 | One-cycle pulse on successful finish |
| fail_o | output | 1 | One-cycle pulse on failed finish |

## Verification
The properties assume that the byte stream is offered only while a load is running. They also assume that `busy_chk_i` is held steady for the whole of a sequence, and that the device status inputs are free to change at any cycle, since no property constrains them. The stimulus changes `busy_chk_i` only between sequences, and it offers bytes only after a load start. It moves `init_i`, `busy_i` and `done_i` at falling clock edges, keeping them high or low for spans both shorter and longer than the timeout so that every wait is seen both ending normally and expiring.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITW,
    ST_WR_ON,
    ST_CS_ON,
    ST_CK_HI,
    ST_FETCH,
    ST_BYTE_LO,
    ST_BYTE_HI,
    ST_BSY_LO,
    ST_BSY_HI,
    ST_CS_OFF,
    ST_WR_OFF,
    ST_DN_HI,
    ST_DN_LO,
    ST_RB_CS,
    ST_RB_CKH,
    ST_RB_LO,
    ST_RB_HI,
    ST_RB_CSOFF,
    ST_RB_FLO,
    ST_RB_FHI,
    ST_PASS,
    ST_ABORT
  } cfg_state_e;

  typedef struct packed {
    logic prog;
    logic cs;
    logic wr;
    logic cclk;
    logic oe;
  } pins_t;

  // Pin levels are a pure function of the sequencer state (Moore outputs).
  function automatic pins_t decode_pins(cfg_state_e s);
    pins_t p;
    p.prog = (s == ST_PROG);
    p.cs   = s inside {ST_CS_ON, ST_CK_HI, ST_FETCH, ST_BYTE_LO, ST_BYTE_HI,
                       ST_BSY_LO, ST_BSY_HI, ST_RB_CS, ST_RB_CKH, ST_RB_LO,
                       ST_RB_HI};
    p.wr   = s inside {ST_WR_ON, ST_CS_ON, ST_CK_HI, ST_FETCH, ST_BYTE_LO,
                       ST_BYTE_HI, ST_BSY_LO, ST_BSY_HI, ST_CS_OFF};
    p.cclk = s inside {ST_CK_HI, ST_FETCH, ST_BYTE_HI, ST_BSY_HI, ST_CS_OFF,
                       ST_WR_OFF, ST_DN_HI, ST_RB_CKH, ST_RB_HI, ST_RB_CSOFF,
                       ST_RB_FHI};
    p.oe   = s inside {ST_PROG, ST_INITW, ST_WR_ON, ST_CS_ON, ST_CK_HI,
                       ST_FETCH, ST_BYTE_LO, ST_BYTE_HI, ST_BSY_LO, ST_BSY_HI,
                       ST_CS_OFF, ST_WR_OFF, ST_DN_HI, ST_DN_LO};
    return p;
  endfunction

endpackage

// File: rtl/cfgld_pace.sv
// Half-period pacer: tick_o is high in the last cycle of each half period.
// restart_i reloads the count so that every new state lasts HALF_CYC cycles.
module cfgld_pace #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i || (cnt_q == '0)) cnt_d = RELOAD;
    else                            cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/cfgld_tmo.sv
// Saturating wait-time counter: runs while run_i, clears otherwise.
module cfgld_tmo #(
  parameter int TMO_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired_o = (cnt_q >= LIMIT);
  assign cnt_en    = !run_i || !expired_o;

  always_comb begin
    if (!run_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfgld_rbcap.sv
// Readback capture: remaining-byte counter and output byte register.
module cfgld_rbcap #(
  parameter int DW    = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             strobe_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    data_o,
  output logic             valid_o,
  output logic             zero_o,
  output logic             last_o
);
  logic [LEN_W-1:0] left_q, left_d;
  logic             left_en;
  logic [DW-1:0]    data_q;
  logic             valid_q;

  assign left_en = load_i || strobe_i;

  always_comb begin
    if (load_i) left_d = len_i;
    else        left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (strobe_i) data_q <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= strobe_i;
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign zero_o  = (left_q == '0);
  assign last_o  = (left_q == LEN_W'(1));
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF_CYC = 2,
  parameter int TMO_CYC  = 1000000,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_rb_i,
  input  logic [LEN_W-1:0] rb_len_i,
  input  logic             busy_chk_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic             cfg_valid_i,
  input  logic             cfg_last_i,
  output logic             cfg_ready_o,
  output logic [DW-1:0]    rb_data_o,
  output logic             rb_valid_o,
  output logic             prog_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic             cclk_o,
  output logic [DW-1:0]    dbus_o,
  output logic             dbus_oe_o,
  input  logic [DW-1:0]    dbus_i,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             abort_o,
  output logic             pass_o,
  output logic             fail_o
);
  // ---------------- reset release synchronizer ----------------
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // ---------------- sequencer state ----------------
  cfg_state_e    state_q, state_d;
  logic          tick, restart, expired, tmo_run;
  logic          take_byte;
  logic [DW-1:0] byte_q;
  logic          last_q;
  logic          rb_load, rb_strobe, rb_zero, rb_last;
  pins_t         pins;

  assign take_byte = (state_q == ST_FETCH) && cfg_valid_i;
  assign restart   = (state_d != state_q);
  assign tmo_run   = state_q inside {ST_INITW, ST_BSY_LO, ST_BSY_HI,
                                     ST_DN_HI, ST_DN_LO};
  assign rb_load   = (state_q == ST_IDLE) && start_i && mode_rb_i;
  assign rb_strobe = (state_q == ST_RB_HI) && tick;

  cfgld_pace #(.HALF_CYC(HALF_CYC)) i_pace (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .restart_i (restart),
    .tick_o    (tick)
  );

  cfgld_tmo #(.TMO_CYC(TMO_CYC)) i_tmo (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run_i     (tmo_run),
    .expired_o (expired)
  );

  cfgld_rbcap #(.DW(DW), .LEN_W(LEN_W)) i_rbcap (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_i   (rb_load),
    .len_i    (rb_len_i),
    .strobe_i (rb_strobe),
    .din_i    (dbus_i),
    .data_o   (rb_data_o),
    .valid_o  (rb_valid_o),
    .zero_o   (rb_zero),
    .last_o   (rb_last)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = mode_rb_i ? ST_RB_CS : ST_PROG;
      ST_PROG:     if (tick) state_d = ST_INITW;
      ST_INITW:
        if (tick) begin
          if (!(init_i && busy_i)) state_d = ST_WR_ON;
          else if (expired)        state_d = ST_ABORT;
        end
      ST_WR_ON:    if (tick) state_d = ST_CS_ON;
      ST_CS_ON:    if (tick) state_d = ST_CK_HI;
      ST_CK_HI:    if (tick) state_d = ST_FETCH;
      ST_FETCH:    if (cfg_valid_i) state_d = ST_BYTE_LO;
      ST_BYTE_LO:  if (tick) state_d = ST_BYTE_HI;
      ST_BYTE_HI:
        if (tick) begin
          if (busy_chk_i && busy_i) state_d = ST_BSY_LO;
          else if (last_q)          state_d = ST_CS_OFF;
          else                      state_d = ST_FETCH;
        end
      ST_BSY_LO:   if (tick) state_d = ST_BSY_HI;
      ST_BSY_HI:
        if (tick) begin
          if (!busy_i)      state_d = last_q ? ST_CS_OFF : ST_FETCH;
          else if (expired) state_d = ST_ABORT;
          else              state_d = ST_BSY_LO;
        end
      ST_CS_OFF:   if (tick) state_d = ST_WR_OFF;
      ST_WR_OFF:   if (tick) state_d = ST_DN_HI;
      ST_DN_HI:
        if (tick) begin
          if (done_i)       state_d = ST_PASS;
          else if (expired) state_d = ST_ABORT;
          else              state_d = ST_DN_LO;
        end
      ST_DN_LO:    if (tick) state_d = ST_DN_HI;
      ST_RB_CS:    if (tick) state_d = ST_RB_CKH;
      ST_RB_CKH:   if (tick) state_d = rb_zero ? ST_RB_CSOFF : ST_RB_LO;
      ST_RB_LO:    if (tick) state_d = ST_RB_HI;
      ST_RB_HI:    if (tick) state_d = rb_last ? ST_RB_CSOFF : ST_RB_LO;
      ST_RB_CSOFF: if (tick) state_d = ST_RB_FLO;
      ST_RB_FLO:   if (tick) state_d = ST_RB_FHI;
      ST_RB_FHI:   if (tick) state_d = ST_PASS;
      ST_PASS:     state_d = ST_IDLE;
      ST_ABORT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      byte_q <= '0;
      last_q <= 1'b0;
    end else if (take_byte) begin
      byte_q <= cfg_data_i;
      last_q <= cfg_last_i;
    end
  end

  // ---------------- outputs ----------------
  assign pins        = decode_pins(state_q);
  assign prog_o      = pins.prog;
  assign cs_o        = pins.cs;
  assign wr_o        = pins.wr;
  assign cclk_o      = pins.cclk;
  assign dbus_oe_o   = pins.oe;
  assign dbus_o      = byte_q;
  assign cfg_ready_o = (state_q == ST_FETCH);
  assign pass_o      = (state_q == ST_PASS);
  assign abort_o     = (state_q == ST_ABORT);
  assign fail_o      = (state_q == ST_ABORT);
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_valid_i,
  input logic cfg_ready_o,
  input logic prog_o,
  input logic cs_o,
  input logic wr_o,
  input logic cclk_o,
  input logic dbus_oe_o,
  input logic rb_valid_o,
  input logic abort_o,
  input logic pass_o,
  input logic fail_o
);
  // R2
  prog_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> (!cs_o && !wr_o && !cclk_o));

  // R4
  cs_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_o) && dbus_oe_o) |-> (wr_o && !cclk_o));

  // R8
  cs_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_o) && dbus_oe_o) |-> wr_o);

  // R5
  byte_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_i && cfg_ready_o) |=> (!cclk_o && cs_o && wr_o));

  // R12
  rb_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid_o |-> (!dbus_oe_o && !wr_o));

  // R12
  ready_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready_o |-> dbus_oe_o);

  // R9
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (!cs_o && !wr_o && !dbus_oe_o && !abort_o));
endmodule

bind cfgld_top cfgld_chk i_chk (.*);

// File: tb/test_cfgld_top.sv
module test_cfgld_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int HALF = 2;
  localparam int TMO = 40;
  localparam int LW = 8;

  // {last, data}
  localparam logic [8:0] LOAD_VEC [6] = '{9'h03C, 9'h0FF, 9'h000, 9'h0A5,
                                          9'h05A, 9'h181};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_rb_i = 1'b0, busy_chk_i = 1'b0;
  logic [LW-1:0] rb_len_i = '0;
  logic [DW-1:0] cfg_data_i = '0;
  logic cfg_valid_i = 1'b0, cfg_last_i = 1'b0;
  logic init_i = 1'b0, busy_i = 1'b0, done_i = 1'b1;
  logic cfg_ready_o, rb_valid_o, prog_o, cs_o, wr_o, cclk_o, dbus_oe_o;
  logic abort_o, pass_o, fail_o;
  logic [DW-1:0] rb_data_o, dbus_o, dbus_i;
  logic [DW-1:0] rb_din = '0;
  assign dbus_i = rb_din;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgld_top #(.DW(DW), .HALF_CYC(HALF), .TMO_CYC(TMO), .LEN_W(LW)) i_cfgld_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_rb_i(mode_rb_i),
    .rb_len_i(rb_len_i), .busy_chk_i(busy_chk_i), .cfg_data_i(cfg_data_i),
    .cfg_valid_i(cfg_valid_i), .cfg_last_i(cfg_last_i), .cfg_ready_o(cfg_ready_o),
    .rb_data_o(rb_data_o), .rb_valid_o(rb_valid_o), .prog_o(prog_o), .cs_o(cs_o),
    .wr_o(wr_o), .cclk_o(cclk_o), .dbus_o(dbus_o), .dbus_oe_o(dbus_oe_o),
    .dbus_i(dbus_i), .init_i(init_i), .busy_i(busy_i), .done_i(done_i),
    .abort_o(abort_o), .pass_o(pass_o), .fail_o(fail_o));

  int n_checks = 0, n_err = 0;

  // ---------------- monitor (samples at falling edge) ----------------
  logic mon_clr = 1'b0;
  int n_fall, cs_rises, post_rises, ord_bad, rel_bad, prog_cur, prog_last;
  int n_pass, n_fail, n_abort, n_rb, oe_cyc;
  logic cs_fell_seen;
  logic [7:0] byte_log [16];
  logic [7:0] rb_log [8];
  logic p_cs = 1'b0, p_wr = 1'b0, p_ck = 1'b0, p_prog = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      n_fall = 0; cs_rises = 0; post_rises = 0; ord_bad = 0; rel_bad = 0;
      prog_cur = 0; prog_last = 0; n_pass = 0; n_fail = 0; n_abort = 0;
      n_rb = 0; oe_cyc = 0; cs_fell_seen = 1'b0;
    end else begin
      if (cclk_o && !p_ck) begin
        if (cs_o) begin
          cs_rises = cs_rises + 1;
          rb_din = 8'hA0 + 8'(cs_rises);
        end
        if (!cs_o && cs_fell_seen) post_rises = post_rises + 1;
      end
      if (!cclk_o && p_ck && cs_o && wr_o) begin
        if (n_fall < 16) byte_log[n_fall] = dbus_o;
        n_fall = n_fall + 1;
      end
      if (cs_o && !p_cs && dbus_oe_o && (!wr_o || cclk_o)) ord_bad = ord_bad + 1;
      if (cs_o && !p_cs && !dbus_oe_o && cclk_o) ord_bad = ord_bad + 1;
      if (!cs_o && p_cs) begin
        cs_fell_seen = 1'b1;
        if (dbus_oe_o && !wr_o) rel_bad = rel_bad + 1;
      end
      if (!wr_o && p_wr && cs_o) rel_bad = rel_bad + 1;
      if (prog_o) prog_cur = prog_cur + 1;
      if (!prog_o && p_prog) begin prog_last = prog_cur; prog_cur = 0; end
      if (pass_o) n_pass = n_pass + 1;
      if (fail_o) n_fail = n_fail + 1;
      if (abort_o) n_abort = n_abort + 1;
      if (dbus_oe_o) oe_cyc = oe_cyc + 1;
      if (rb_valid_o) begin
        if (n_rb < 8) rb_log[n_rb] = rb_data_o;
        n_rb = n_rb + 1;
      end
    end
    p_cs = cs_o; p_wr = wr_o; p_ck = cclk_o; p_prog = prog_o;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic kick(input logic rb, input int len);
    start_i = 1'b1; mode_rb_i = rb; rb_len_i = LW'(len);
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic l);
    cfg_data_i = d; cfg_last_i = l; cfg_valid_i = 1'b1;
    while (!cfg_ready_o) @(negedge clk);
    @(negedge clk); cfg_valid_i = 1'b0;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send_byte(8'(8'h10 + i), (i == n - 1));
  endtask

  task automatic wait_end(input string req, input int maxc);
    int base;
    int k;
    base = n_pass + n_fail;
    k = 0;
    while ((n_pass + n_fail) == base && k < maxc) begin
      @(negedge clk); k++;
    end
    if (k >= maxc) chk({req, " sequence end"}, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_pins(input string req);
    chk({req, " prog"}, int'(prog_o), 0);
    chk({req, " cs"}, int'(cs_o), 0);
    chk({req, " wr"}, int'(wr_o), 0);
    chk({req, " cclk"}, int'(cclk_o), 0);
    chk({req, " oe"}, int'(dbus_oe_o), 0);
    chk({req, " ready"}, int'(cfg_ready_o), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    mon_clr = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
    // R1 reset state
    idle_pins("R1");
    chk("R1 rb_valid", int'(rb_valid_o), 0);
    chk("R1 pass/fail/abort", int'(pass_o) + int'(fail_o) + int'(abort_o), 0);

    // Table walk: R2 R3 R4 R5 R8 R9 (init high, busy low = not both set)
    clr(); init_i = 1'b1; busy_i = 1'b0; done_i = 1'b1; busy_chk_i = 1'b0;
    kick(1'b0, 0);
    for (int i = 0; i < 6; i++) send_byte(LOAD_VEC[i][7:0], LOAD_VEC[i][8]);
    wait_end("R5", 500);
    for (int i = 0; i < 6; i++) chk("R5 byte on bus", int'(byte_log[i]), int'(LOAD_VEC[i][7:0]));
    chk("R5 one fall per byte", n_fall, 6);
    chk("R2 prog width", prog_last, HALF);
    chk("R4 strobe order", ord_bad, 0);
    chk("R8 release order", rel_bad, 0);
    chk("R9 pass", n_pass, 1);
    chk("R9 no extra pulses with done high", post_rises, 0);
    idle_pins("R9 after pass");

    // R3: init and busy both high hold the sequence, then release
    clr(); init_i = 1'b1; busy_i = 1'b1;
    kick(1'b0, 0);
    repeat (20) @(negedge clk);
    chk("R3 prog released", int'(prog_o), 0);
    chk("R3 wr held off", int'(wr_o), 0);
    init_i = 1'b0;
    send_n(1);
    wait_end("R3", 500);
    chk("R3 pass after release", n_pass, 1);
    busy_i = 1'b0;

    // R3: init timeout
    clr(); init_i = 1'b1; busy_i = 1'b1;
    kick(1'b0, 0);
    wait_end("R3", 500);
    chk("R3 timeout abort", n_abort, 1);
    chk("R3 timeout fail", n_fail, 1);
    chk("R3 no pass", n_pass, 0);
    chk("R3 no write", n_fall, 0);
    idle_pins("R3 after abort");
    init_i = 1'b0; busy_i = 1'b0;

    // R6: busy check, busy high for a while after first byte
    clr(); busy_chk_i = 1'b1;
    kick(1'b0, 0);
    fork
      send_n(2);
      begin
        while (n_fall < 1) @(negedge clk);
        busy_i = 1'b1;
        repeat (12) @(negedge clk);
        busy_i = 1'b0;
      end
    join
    wait_end("R6", 500);
    chk("R6 extra pulses while busy", int'(n_fall > 2), 1);
    chk("R6 pass", n_pass, 1);

    // R6: busy stuck -> timeout
    clr(); busy_i = 1'b1; busy_chk_i = 1'b1;
    kick(1'b0, 0);
    send_n(1);
    wait_end("R6", 500);
    chk("R6 busy timeout abort", n_abort, 1);
    chk("R6 busy timeout fail", n_fail, 1);
    idle_pins("R6 after abort");

    // R7: busy ignored when check disabled
    clr(); busy_i = 1'b1; busy_chk_i = 1'b0;
    kick(1'b0, 0);
    send_n(3);
    wait_end("R7", 500);
    chk("R7 one fall per byte", n_fall, 3);
    chk("R7 pass", n_pass, 1);
    busy_i = 1'b0;

    // R9: done late -> extra pulses then pass
    clr(); done_i = 1'b0;
    kick(1'b0, 0);
    send_n(1);
    while (!(cclk_o == 1'b0 && !wr_o && dbus_oe_o)) @(negedge clk);
    repeat (8) @(negedge clk);
    done_i = 1'b1;
    wait_end("R9", 500);
    chk("R9 pulses until done", int'(post_rises > 0), 1);
    chk("R9 pass after done", n_pass, 1);
    chk("R9 no fail", n_fail, 0);

    // R9: done never -> timeout
    clr(); done_i = 1'b0;
    kick(1'b0, 0);
    send_n(1);
    wait_end("R9", 500);
    chk("R9 done timeout abort", n_abort, 1);
    chk("R9 done timeout fail", n_fail, 1);
    chk("R9 no pass", n_pass, 0);
    done_i = 1'b1;

    // R10 R11 R12: readback of 3 bytes
    clr();
    kick(1'b1, 3);
    wait_end("R10", 500);
    chk("R10 byte count", n_rb, 3);
    for (int j = 0; j < 3; j++) chk("R10 sampled byte", int'(rb_log[j]), 8'hA0 + j + 2);
    chk("R10 no write strobe", n_fall, 0);
    chk("R10 cs with clock low", ord_bad, 0);
    chk("R11 one pulse after cs release", post_rises, 1);
    chk("R12 no bus drive in readback", oe_cyc, 0);
    chk("R10 pass", n_pass, 1);

    // R10: zero-length readback
    clr();
    kick(1'b1, 0);
    wait_end("R10", 500);
    chk("R10 zero length no bytes", n_rb, 0);
    chk("R11 zero length final pulse", post_rises, 1);
    chk("R10 zero length pass", n_pass, 1);

    // R13: start during a load is ignored
    clr();
    kick(1'b0, 0);
    fork
      send_n(2);
      begin
        while (n_fall < 1) @(negedge clk);
        kick(1'b1, 4);
      end
    join
    wait_end("R13", 500);
    repeat (20) @(negedge clk);
    chk("R13 no readback bytes", n_rb, 0);
    chk("R13 single pass", n_pass, 1);
    chk("R13 bytes written", n_fall, 2);
    chk("R13 idle after", int'(cs_o), 0);

    // R1: reset in the middle of a readback
    clr();
    kick(1'b1, 5);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_pins("R1 mid-run reset");
    chk("R1 mid-run reset rb_valid", int'(rb_valid_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    idle_pins("R1 after reset release");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule